// File: doc/BRIEF.md
# Banked Read Command Sequencer with Open-Row Tracking

This block turns read requests into a minimal series of memory commands for a banked dynamic memory. A request names a bank, a row and a column. It arrives on a valid/ready port. For every bank the block remembers which row, if any, is currently open. From that it chooses one of three command paths:

- **Row hit.** The requested row is already open, so the block issues a column read alone.
- **Idle bank.** No row is open in that bank, so the block issues a row open followed by a column read.
- **Row conflict.** A different row is open, so the block closes that row, opens the requested one and then issues the column read.

Waits between commands are filled with no-operation cycles. Their lengths come from the close-to-open, open-to-read and read-to-data delay parameters.

Rows stay open after a read, so later requests to the same row take the short path. The memory device returns a burst of consecutive column words. The block forwards these words on its response port, one per cycle. It flags each word as valid and marks the last word of the burst. Only one request is in service at a time.

Top module: `rdseq_top`

## Requirements
- R1: Synchronous active-high reset marks every bank as having no open row, raises `req_ready`, drives the NOP command (code 0) and holds `rsp_valid` and `rsp_last` low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Call the cycle after that edge cycle 1. `req_ready` stays low from cycle 1 up to and including the cycle of the last response word, and it is high again in the cycle after that word.
- R3: On a row conflict the block issues PRECHARGE in cycle 1, ACTIVATE in cycle 1+T_RP and READ in cycle 1+T_RP+T_RCD. The first data word is presented T_CL cycles after READ. With the defaults this is 6 cycles from the first command.
- R4: When the bank has no open row, the block issues ACTIVATE in cycle 1 and READ in cycle 1+T_RCD. The first word follows T_CL cycles after READ, which is 4 cycles with the defaults.
- R5: When the requested row is already open in its bank, the block issues READ in cycle 1. The first word follows T_CL cycles later, which is 2 cycles with the defaults.
- R6: The response is BURST_LEN consecutive cycles with `rsp_valid` high. `rsp_data` equals `mem_rdata` in each of those cycles. `rsp_last` is high only in the final cycle. Outside the burst, `rsp_data` is zero.
- R7: On every non-NOP command, `cmd_bank` carries the requested bank. On ACTIVATE, `cmd_row` carries the requested row. On READ, `cmd_col` carries the requested column.
- R8: Command codes are NOP=0, PRECHARGE=1, ACTIVATE=2 and READ=3. Every cycle that does not issue one of the commands named in R3 to R5 carries NOP.
- R9: After a read the row remains open. Each bank's open row is changed only by commands addressed to that bank, so accesses to other banks do not turn a later hit into a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_bank | input | BANK_W | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested starting column |
| cmd_op | output | 2 | Command code (NOP 0, PRECHARGE 1, ACTIVATE 2, READ 3) |
| cmd_bank | output | BANK_W | Bank for the command |
| cmd_row | output | ROW_W | Row for the command |
| cmd_col | output | COL_W | Column for the command |
| mem_rdata | input | DATA_W | Data word from the memory device |
| rsp_valid | output | 1 | Response word valid |
| rsp_last | output | 1 | Final word of the burst |
| rsp_data | output | DATA_W | Response word |

## Verification
The bench sweeps every bank against every row, then revisits each row with a new column. This makes each bank pass through the idle, conflict and hit paths. A design that compared rows against the wrong bank's entry, or cleared an entry after reading, would pick the long path where the short one applies. It would then issue an extra PRECHARGE or ACTIVATE in cycle 1.

A closing pass touches all four banks after the others were used, to catch shared open-row state between banks. A reset in mid-run must force the next access back to the idle-bank path.

Off-by-one errors in any wait counter move the ACTIVATE, READ or first data word by one cycle. Each of these is caught by per-cycle comparison against arithmetic schedules. A burst counter that runs one beat short or long shows up as a misplaced `rsp_last` or an early or late `req_ready`.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_ACT,
        ST_WAIT_RCD,
        ST_RD,
        ST_WAIT_CL,
        ST_BURST
    } seq_st_e;

endpackage

// File: rtl/rdseq_bank_table.sv
module rdseq_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic              set_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_match
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_ent_t;

    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_W-1:0]     row_arr [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_ent_t ent_d;
        bank_ent_t ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_bank == BANK_W'(g)) begin
                if (clr_en) begin
                    ent_d.open = 1'b0;
                end
                if (set_en) begin
                    ent_d.open = 1'b1;
                    ent_d.row  = wr_row;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign open_vec[g] = ent_q.open;
        assign row_arr[g]  = ent_q.row;
    end

    always_comb begin
        lk_open  = 1'b0;
        lk_match = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (lk_bank == BANK_W'(i)) begin
                lk_open  = open_vec[i];
                lk_match = (row_arr[i] == lk_row);
            end
        end
    end

endmodule

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
    import rdseq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2,
    parameter int T_CL      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              lk_open,
    input  logic              lk_match,
    output logic              req_ready,
    output cmd_e              cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              upd_clr,
    output logic              upd_set,
    output logic              rsp_valid,
    output logic              rsp_last
);

    localparam int MAX_T_A = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int MAX_T   = (MAX_T_A > T_CL) ? MAX_T_A : T_CL;
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam int BEAT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } ctrl_s;

    ctrl_s s_d;
    ctrl_s s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.bank = req_bank;
                    s_d.row  = req_row;
                    s_d.col  = req_col;
                    if (!lk_open) begin
                        s_d.st = ST_ACT;
                    end else if (lk_match) begin
                        s_d.st = ST_RD;
                    end else begin
                        s_d.st = ST_PRE;
                    end
                end
            end
            ST_PRE: begin
                if (T_RP > 1) begin
                    s_d.st  = ST_WAIT_RP;
                    s_d.cnt = CNT_W'(T_RP - 1);
                end else begin
                    s_d.st = ST_ACT;
                end
            end
            ST_WAIT_RP: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st = ST_ACT;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_ACT: begin
                if (T_RCD > 1) begin
                    s_d.st  = ST_WAIT_RCD;
                    s_d.cnt = CNT_W'(T_RCD - 1);
                end else begin
                    s_d.st = ST_RD;
                end
            end
            ST_WAIT_RCD: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st = ST_RD;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_RD: begin
                s_d.beat = '0;
                if (T_CL > 1) begin
                    s_d.st  = ST_WAIT_CL;
                    s_d.cnt = CNT_W'(T_CL - 1);
                end else begin
                    s_d.st = ST_BURST;
                end
            end
            ST_WAIT_CL: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.st = ST_BURST;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_BURST: begin
                if (s_q.beat == BEAT_W'(BURST_LEN - 1)) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.beat = s_q.beat + BEAT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.st)
            ST_PRE:  cmd_op = CMD_PRE;
            ST_ACT:  cmd_op = CMD_ACT;
            ST_RD:   cmd_op = CMD_RD;
            default: cmd_op = CMD_NOP;
        endcase
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign cmd_bank  = s_q.bank;
    assign cmd_row   = s_q.row;
    assign cmd_col   = s_q.col;
    assign upd_clr   = (s_q.st == ST_PRE);
    assign upd_set   = (s_q.st == ST_ACT);
    assign rsp_valid = (s_q.st == ST_BURST);
    assign rsp_last  = (s_q.st == ST_BURST) && (s_q.beat == BEAT_W'(BURST_LEN - 1));

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 16,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2,
    parameter int T_CL      = 2,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data
);

    logic lk_open;
    logic lk_match;
    logic upd_clr;
    logic upd_set;
    cmd_e cmd_op_e;

    rdseq_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W)
    ) table_i (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (upd_clr),
        .set_en   (upd_set),
        .wr_bank  (cmd_bank),
        .wr_row   (cmd_row),
        .lk_bank  (req_bank),
        .lk_row   (req_row),
        .lk_open  (lk_open),
        .lk_match (lk_match)
    );

    rdseq_ctrl #(
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .T_RP      (T_RP),
        .T_RCD     (T_RCD),
        .T_CL      (T_CL),
        .BURST_LEN (BURST_LEN)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .lk_open   (lk_open),
        .lk_match  (lk_match),
        .req_ready (req_ready),
        .cmd_op    (cmd_op_e),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .cmd_col   (cmd_col),
        .upd_clr   (upd_clr),
        .upd_set   (upd_set),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last)
    );

    assign cmd_op   = cmd_op_e;
    assign rsp_data = rsp_valid ? mem_rdata : '0;

endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
    parameter int T_RP  = 2,
    parameter int T_RCD = 2,
    parameter int T_CL  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic [1:0] cmd_op,
    input logic       rsp_valid,
    input logic       rsp_last
);

    logic [7:0] since_q;
    logic [1:0] last_op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= 8'd0;
            last_op_q <= 2'd0;
        end else if (cmd_op != 2'd0) begin
            since_q   <= 8'd1;
            last_op_q <= cmd_op;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && cmd_op == 2'd0 && !rsp_valid && !rsp_last));

    p_busy_during_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_pre_to_act_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd2 && last_op_q == 2'd1) |-> (since_q == 8'(T_RP)));

    p_act_to_rd_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd3 && last_op_q == 2'd2) |-> (since_q == 8'(T_RCD)));

    p_rd_to_data_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> (last_op_q == 2'd3 && since_q == 8'(T_CL)));

    p_last_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    p_last_ends_burst_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_last |=> !rsp_valid);

    p_cmd_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_op != 2'd0) |-> !req_ready);

endmodule

bind rdseq_top rdseq_checker #(
    .T_RP  (T_RP),
    .T_RCD (T_RCD),
    .T_CL  (T_CL)
) checker_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last)
);

// File: tb/rdseq_top_tb_top.sv
module rdseq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int BW    = 2;
    localparam int RW    = 4;
    localparam int CW    = 4;
    localparam int DW    = 16;
    localparam int T_RP  = 2;
    localparam int T_RCD = 2;
    localparam int T_CL  = 2;
    localparam int BL    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [1:0]    cmd_op;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic [DW-1:0] mem_rdata = '0;
    logic          rsp_valid;
    logic          rsp_last;
    logic [DW-1:0] rsp_data;

    int n_chk = 0;
    int n_err = 0;
    bit mv [NB];
    int mr [NB];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdseq_top #(
        .NUM_BANKS (NB), .ROW_W (RW), .COL_W (CW), .DATA_W (DW),
        .T_RP (T_RP), .T_RCD (T_RCD), .T_CL (T_CL), .BURST_LEN (BL)
    ) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .cmd_op (cmd_op), .cmd_bank (cmd_bank), .cmd_row (cmd_row), .cmd_col (cmd_col),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid), .rsp_last (rsp_last), .rsp_data (rsp_data)
    );

    function automatic logic [DW-1:0] dval(input int b, input int r, input int c, input int i);
        return DW'(32'hA000 | (b << 8) | (r << 4) | ((c + i) & 15));
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_req(input int b, input int r, input int c, input string extra);
        int cls;
        int k_pre, k_act, k_rd, k_first, k_end;
        int rd_seen, rd_b, rd_r, rd_c, op, eop;
        bit ev;
        string tag;
        if (!mv[b]) cls = 1;
        else if (mr[b] == r) cls = 0;
        else cls = 2;
        k_pre = (cls == 2) ? 1 : -1;
        k_act = (cls == 2) ? 1 + T_RP : ((cls == 1) ? 1 : -1);
        k_rd  = (cls == 2) ? 1 + T_RP + T_RCD : ((cls == 1) ? 1 + T_RCD : 1);
        k_first = k_rd + T_CL;
        k_end   = k_first + BL;
        tag = (cls == 2) ? "R3 R8" : ((cls == 1) ? "R4 R8" : "R5 R8");
        tag = {tag, " ", extra};
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_col   = CW'(c);
        mem_rdata = '0;
        #1;
        check(req_ready == 1'b1, "R2 ready before accept", int'(req_ready), 1);
        rd_seen = -1;
        rd_b = 0; rd_r = 0; rd_c = 0;
        for (int k = 1; k <= k_end; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            op = int'(cmd_op);
            if (op == 3 && rd_seen < 0) begin
                rd_seen = k;
                rd_b = int'(cmd_bank);
                rd_r = int'(cmd_row);
                rd_c = int'(cmd_col);
            end
            if (rd_seen > 0 && k >= rd_seen + T_CL && k < rd_seen + T_CL + BL)
                mem_rdata = dval(rd_b, rd_r, rd_c, k - rd_seen - T_CL);
            else
                mem_rdata = '0;
            #1;
            eop = (k == k_pre) ? 1 : (k == k_act) ? 2 : (k == k_rd) ? 3 : 0;
            check(op == eop, {tag, " command code"}, op, eop);
            if (eop != 0) begin
                check(int'(cmd_bank) == b, "R7 cmd_bank", int'(cmd_bank), b);
                if (eop == 2) check(int'(cmd_row) == r, "R7 cmd_row on activate", int'(cmd_row), r);
                if (eop == 3) check(int'(cmd_col) == c, "R7 cmd_col on read", int'(cmd_col), c);
            end
            ev = (k >= k_first) && (k < k_end);
            check(rsp_valid == ev, {"R6 rsp_valid ", tag}, int'(rsp_valid), int'(ev));
            check(rsp_last == (k == k_end - 1), "R6 rsp_last", int'(rsp_last), int'(k == k_end - 1));
            if (ev)
                check(rsp_data == dval(b, r, c, k - k_first), "R6 rsp_data",
                      int'(rsp_data), int'(dval(b, r, c, k - k_first)));
            else
                check(rsp_data == '0, "R6 rsp_data idle", int'(rsp_data), 0);
            check(req_ready == (k == k_end), "R2 ready while busy", int'(req_ready), int'(k == k_end));
        end
        if (cls != 0) begin
            mv[b] = 1'b1;
            mr[b] = r;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            mv[i] = 1'b0;
            mr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        check(cmd_op == 2'd0, "R1 reset command NOP", int'(cmd_op), 0);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        check(rsp_last == 1'b0, "R1 reset rsp_last", int'(rsp_last), 0);

        // Sweep every bank over every row: idle/conflict then hit with a new column
        for (int b = 0; b < NB; b++) begin
            for (int r = 0; r < 16; r++) begin
                run_req(b, (r * 7 + b) % 16, r, "sweep");
                run_req(b, (r * 7 + b) % 16, 15 - r, "R9 hit after read");
            end
        end

        // Each bank kept its own last row across the other banks' traffic
        for (int b = 0; b < NB; b++) begin
            run_req(b, mr[b], b + 3, "R9 bank independence");
        end

        // Reset in mid-run clears the open rows
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(cmd_op == 2'd0, "R1 NOP after reset", int'(cmd_op), 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        for (int i = 0; i < NB; i++) mv[i] = 1'b0;
        for (int b = 0; b < NB; b++) begin
            run_req(b, mr[b], 1, "R1 bank cleared by reset");
        end
        run_req(2, 9, 0, "conflict after reset");
        run_req(2, 9, 5, "R9 hit");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule